// File: doc/BRIEF.md
# Circular Shift Segment Animator

This block holds a short bit pattern that drives a group of display segments and rotates it by one position whenever a chosen frame-rate tick arrives. After a one-time setup, an animation such as a running light or a spinner moves on its own, with no processor involvement. The setup gives the pattern, the length of the rotating window, the direction, and which of three frame-counter overflow ticks paces the motion.

A single write strobe loads the whole setup, and the block accepts it only while the animation is stopped. The window can be any length up to the register width of 16 bits. Bits outside the window are held at zero, so segments past the window stay dark. Each output bit maps straight to the drive data of one segment.

Top module: `seg_rotator`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pattern_o` becomes all zero, the stored length becomes 0, the direction becomes left and the tick choice becomes 3 (no tick).
- R2: When `cfg_we` is high and `run_en` is low at a clock edge, `pattern_o` shows `cfg_init` with every bit at or above the new length cleared, starting in the next cycle. Length, direction and tick choice are stored in the same edge. A `cfg_len` above 16 counts as 16.
- R3: A `cfg_we` pulse while `run_en` is high is ignored. Pattern, length, direction and tick choice all stay as they were.
- R4: With `cfg_dir` = 0 (left) and length n >= 2, one step moves bit i to bit i+1 for i < n-1 and moves bit n-1 to bit 0.
- R5: With `cfg_dir` = 1 (right) and length n >= 2, one step moves bit i to bit i-1 for 0 < i < n and moves bit 0 to bit n-1.
- R6: A tick choice of 0, 1 or 2 makes `tick_in[0]`, `tick_in[1]` or `tick_in[2]` the step source. The other tick lines have no effect. A choice of 3 selects no tick at all.
- R7: Each clock edge at which `run_en` and the selected tick are both high makes exactly one step. A tick held high for k edges makes k steps.
- R8: While `run_en` is low, ticks change nothing. The pattern changes only through a load.
- R9: With a stored length of 0 or 1, steps leave the pattern unchanged.
- R10: Bits of `pattern_o` at or above the stored length are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Animation enable; also blocks setup writes while high |
| cfg_we | input | 1 | Setup write strobe |
| cfg_len | input | 5 | Window length, 0 to 16 (larger values act as 16) |
| cfg_dir | input | 1 | 0 = left (toward higher index), 1 = right |
| cfg_sel | input | 2 | Tick choice: 0..2 = tick line, 3 = none |
| cfg_init | input | 16 | Initial pattern |
| tick_in | input | 3 | Frame-counter overflow tick pulses |
| pattern_o | output | 16 | Current segment pattern |

## Verification
A setup write and a rotation step can fall in the same cycle. The block settles that conflict with `run_en`: a load wins while the block is stopped, and a step wins while it runs. The bench provokes the conflict by raising `cfg_we` together with the selected tick, once with `run_en` low and once with it high. A behavioural reference model, compared on every clock, then decides whether the pattern shows the new load or one rotation of the old pattern. Later steps reveal whether the stored direction and length were left intact.

// File: rtl/sar_pkg.sv
// Shared types for the segment rotator.
package sar_pkg;
    // Rotation direction: left moves bits toward higher indices.
    typedef enum logic {
        ROT_LEFT  = 1'b0,
        ROT_RIGHT = 1'b1
    } rot_dir_e;
endpackage

// File: rtl/sar_cfg.sv
// Setup register bank.
// Holds the window length, direction and tick choice. It accepts a write
// only while the animation is stopped and clamps the length to W.
// Assumes: cfg_we is one write per cycle; reset is synchronous active-low.
module sar_cfg
    import sar_pkg::*;
#(
    parameter int W  = 16,
    parameter int NT = 3,
    parameter int LW = $clog2(W + 1),
    parameter int SW = $clog2(NT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          cfg_we,
    input  logic [LW-1:0] cfg_len,
    input  logic          cfg_dir,
    input  logic [SW-1:0] cfg_sel,
    output logic          load_o,
    output logic [LW-1:0] load_len_o,
    output logic [LW-1:0] len_q,
    rot_dir_e             dir_q,
    output logic [SW-1:0] sel_q
);
    localparam logic [LW-1:0] LEN_MAX  = LW'(W);
    localparam logic [SW-1:0] SEL_NONE = SW'(NT);

    // Accept a write only while stopped; clamp the length to the register width.
    always_comb begin
        load_o     = cfg_we && !run_en;
        load_len_o = (cfg_len > LEN_MAX) ? LEN_MAX : cfg_len;
    end

    // Store the setup fields on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            dir_q <= ROT_LEFT;
            sel_q <= SEL_NONE;
        end else if (load_o) begin
            len_q <= load_len_o;
            dir_q <= rot_dir_e'(cfg_dir);
            sel_q <= cfg_sel;
        end
    end
endmodule

// File: rtl/sar_tick_pick.sv
// Tick selector.
// Raises step_o when the animation runs and the chosen tick line is high.
// A choice at or above NT selects no line.
// Assumes: ticks are synchronous to clk.
module sar_tick_pick #(
    parameter int NT = 3,
    parameter int SW = $clog2(NT + 1)
) (
    input  logic          run_en,
    input  logic [SW-1:0] sel_q,
    input  logic [NT-1:0] tick_in,
    output logic          step_o
);
    logic [NT-1:0] sel_hot;

    // One-hot decode of the tick choice.
    for (genvar k = 0; k < NT; k++) begin : g_hot
        assign sel_hot[k] = (sel_q == SW'(k));
    end

    // Gate the chosen tick with the enable.
    always_comb begin
        step_o = run_en && |(tick_in & sel_hot);
    end
endmodule

// File: rtl/sar_rotate_core.sv
// Pattern register with a variable-length rotation window.
// A load stores the initial pattern masked to the new length. A step
// rotates bits 0..len-1 by one place in the stored direction, and lengths
// below 2 leave the pattern unchanged.
// Assumes: len_q <= W; load and step are never both high (the caller gates them).
module sar_rotate_core
    import sar_pkg::*;
#(
    parameter int W  = 16,
    parameter int LW = $clog2(W + 1),
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] load_len,
    input  logic [W-1:0]  init,
    input  logic          step,
    input  logic [LW-1:0] len_q,
    input  rot_dir_e      dir_q,
    output logic [W-1:0]  pat_q
);
    logic [W-1:0]  load_mask;
    logic [W-1:0]  run_mask;
    logic [W-1:0]  rot_next;
    logic [LW-1:0] last_pos;
    logic [IW-1:0] last_idx;

    // Position of the highest bit inside the window.
    always_comb begin
        last_pos = len_q - LW'(1);
        last_idx = last_pos[IW-1:0];
    end

    // Per-bit window masks and rotated next value.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic lsrc;
        logic rsrc;
        assign load_mask[i] = (load_len > LW'(i));
        assign run_mask[i]  = (len_q > LW'(i));
        if (i == 0) begin : g_l0
            assign lsrc = pat_q[last_idx];
        end else begin : g_ln
            assign lsrc = pat_q[i-1];
        end
        if (i == W - 1) begin : g_rtop
            assign rsrc = pat_q[0];
        end else begin : g_rn
            assign rsrc = (LW'(i) == last_pos) ? pat_q[0] : pat_q[i+1];
        end
        assign rot_next[i] = run_mask[i] && ((dir_q == ROT_LEFT) ? lsrc : rsrc);
    end

    // Update the pattern on reset, load or a step with a usable window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q <= '0;
        end else if (load) begin
            pat_q <= init & load_mask;
        end else if (step && (len_q > LW'(1))) begin
            pat_q <= rot_next;
        end
    end
endmodule

// File: rtl/seg_rotator.sv
// Circular shift segment animator, top level.
// Connects the setup bank, the tick selector and the rotation core.
// Assumes: synchronous active-low reset; tick lines are clk-synchronous pulses.
module seg_rotator #(
    parameter int W  = 16,
    parameter int NT = 3,
    parameter int LW = $clog2(W + 1),
    parameter int SW = $clog2(NT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          cfg_we,
    input  logic [LW-1:0] cfg_len,
    input  logic          cfg_dir,
    input  logic [SW-1:0] cfg_sel,
    input  logic [W-1:0]  cfg_init,
    input  logic [NT-1:0] tick_in,
    output logic [W-1:0]  pattern_o
);
    logic             load;
    logic [LW-1:0]    load_len;
    logic [LW-1:0]    len_q;
    sar_pkg::rot_dir_e dir_q;
    logic [SW-1:0]    sel_q;
    logic             step;

    sar_cfg #(.W(W), .NT(NT), .LW(LW), .SW(SW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .cfg_we     (cfg_we),
        .cfg_len    (cfg_len),
        .cfg_dir    (cfg_dir),
        .cfg_sel    (cfg_sel),
        .load_o     (load),
        .load_len_o (load_len),
        .len_q      (len_q),
        .dir_q      (dir_q),
        .sel_q      (sel_q)
    );

    sar_tick_pick #(.NT(NT), .SW(SW)) u_pick (
        .run_en  (run_en),
        .sel_q   (sel_q),
        .tick_in (tick_in),
        .step_o  (step)
    );

    sar_rotate_core #(.W(W), .LW(LW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_len (load_len),
        .init     (cfg_init),
        .step     (step),
        .len_q    (len_q),
        .dir_q    (dir_q),
        .pat_q    (pattern_o)
    );
endmodule

// File: rtl/sar_checker.sv
// Property checker for seg_rotator, attached through bind.
// Assumes: it is connected to the top's ports and stored setup fields.
module sar_checker #(
    parameter int W  = 16,
    parameter int NT = 3,
    parameter int LW = $clog2(W + 1),
    parameter int SW = $clog2(NT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_en,
    input logic          cfg_we,
    input logic [W-1:0]  cfg_init,
    input logic [W-1:0]  pattern_o,
    input logic [LW-1:0] len_q,
    input logic          dir_q,
    input logic [SW-1:0] sel_q
);
    // R10: nothing lit outside the window
    a_r10_outside_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_o >> len_q) == '0);

    // R2: a load shows only bits present in the initial value
    a_r2_load_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !run_en) |=> ((pattern_o & ~$past(cfg_init)) == '0));

    // R3: setup is frozen while running
    a_r3_setup_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && run_en) |=> ($stable(len_q) && $stable(dir_q) && $stable(sel_q)));

    // R8: stopped and not loading, the pattern holds
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cfg_we) |=> $stable(pattern_o));

    // R4 and R5: rotation keeps the number of lit segments
    a_r4_ones_kept: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> ($countones(pattern_o) == $countones($past(pattern_o))));

    // R9: short windows never move
    a_r9_short_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && len_q < LW'(2)) |=> $stable(pattern_o));

    // R6: the no-tick choice never moves the pattern
    a_r6_no_source: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && sel_q >= SW'(NT)) |=> $stable(pattern_o));
endmodule

bind seg_rotator sar_checker #(.W(W), .NT(NT), .LW(LW), .SW(SW)) u_sar_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .cfg_we    (cfg_we),
    .cfg_init  (cfg_init),
    .pattern_o (pattern_o),
    .len_q     (len_q),
    .dir_q     (dir_q),
    .sel_q     (sel_q)
);

// File: tb/test_seg_rotator.sv
module test_seg_rotator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_len = '0;
    logic        cfg_dir = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_init = '0;
    logic [2:0]  tick_in = '0;
    logic [15:0] pattern_o;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    logic [15:0] m_pat;
    int          m_len;
    logic        m_dir;
    int          m_sel;

    always #4 clk = ~clk;

    seg_rotator i_seg_rotator (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
        .cfg_len(cfg_len), .cfg_dir(cfg_dir), .cfg_sel(cfg_sel),
        .cfg_init(cfg_init), .tick_in(tick_in), .pattern_o(pattern_o)
    );

    function automatic int clamp_len(input logic [4:0] l);
        return (int'(l) > 16) ? 16 : int'(l);
    endfunction

    function automatic logic [15:0] keep_low(input logic [15:0] v, input int n);
        logic [15:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = v[i];
        return r;
    endfunction

    function automatic logic [15:0] rot(input logic [15:0] p, input int n, input logic d);
        logic [15:0] r = p;
        if (n < 2) return p;
        if (!d) begin
            r[0] = p[n-1];
            for (int i = 1; i < n; i++) r[i] = p[i-1];
        end else begin
            r[n-1] = p[0];
            for (int i = 0; i < n - 1; i++) r[i] = p[i+1];
        end
        return r;
    endfunction

    // behavioural model, one update per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pat <= '0; m_len <= 0; m_dir <= 1'b0; m_sel <= 3;
        end else if (!run_en && cfg_we) begin
            m_len <= clamp_len(cfg_len);
            m_dir <= cfg_dir;
            m_sel <= int'(cfg_sel);
            m_pat <= keep_low(cfg_init, clamp_len(cfg_len));
        end else if (run_en && m_sel < 3 && tick_in[m_sel]) begin
            m_pat <= rot(m_pat, m_len, m_dir);
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) chk({cur_req, " model"}, pattern_o, m_pat);
    end

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input int len, input logic d, input int sel, input logic [15:0] v);
        cfg_we = 1'b1; cfg_len = 5'(len); cfg_dir = d; cfg_sel = 2'(sel); cfg_init = v;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] t);
        tick_in = t; cyc(); tick_in = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        cyc(3);
        cur_req = "R1";
        chk("R1 reset pattern", pattern_o, 16'h0000);
        rst_n = 1'b1;
        run_en = 1'b1; pulse(3'b111); run_en = 1'b0;
        chk("R1 no tick source after reset", pattern_o, 16'h0000);

        // left rotation over the full width
        cur_req = "R2";
        load(16, 1'b0, 0, 16'h8001);
        chk("R2 load full width", pattern_o, 16'h8001);
        cur_req = "R4";
        run_en = 1'b1; pulse(3'b001);
        chk("R4 left wrap", pattern_o, 16'h0003);
        pulse(3'b001); pulse(3'b001);
        chk("R4 left steps", pattern_o, 16'h000C);
        run_en = 1'b0; cyc();

        // right rotation over a short window with masking
        cur_req = "R10";
        load(5, 1'b1, 1, 16'hFFF3);
        chk("R10 mask on load", pattern_o, 16'h0013);
        cur_req = "R5";
        run_en = 1'b1; pulse(3'b010);
        chk("R5 right wrap", pattern_o, 16'h0019);
        cur_req = "R6";
        pulse(3'b101);
        chk("R6 unselected ticks", pattern_o, 16'h0019);

        // write while running is ignored
        cur_req = "R3";
        load(16, 1'b0, 0, 16'hFFFF);
        chk("R3 write ignored", pattern_o, 16'h0019);
        pulse(3'b010);
        chk("R3 setup kept", pattern_o, 16'h001C);

        // stopped: ticks ignored
        cur_req = "R8";
        run_en = 1'b0; pulse(3'b111); pulse(3'b010);
        chk("R8 ticks ignored while stopped", pattern_o, 16'h001C);

        // collision: load and tick together while stopped -> load wins
        cur_req = "R2";
        tick_in = 3'b111;
        load(8, 1'b0, 2, 16'h00A5);
        tick_in = '0;
        chk("R2 load wins when stopped", pattern_o, 16'h00A5);
        // collision while running -> step wins
        cur_req = "R3";
        run_en = 1'b1; tick_in = 3'b100;
        load(4, 1'b1, 0, 16'h0001);
        tick_in = '0;
        chk("R3 step wins when running", pattern_o, 16'h004B);

        // held tick: one step per cycle
        cur_req = "R7";
        tick_in = 3'b100; cyc(3); tick_in = '0;
        chk("R7 three steps", pattern_o, 16'h005A);
        run_en = 1'b0; cyc();

        // no-source choice
        cur_req = "R6";
        load(8, 1'b0, 3, 16'h0081);
        run_en = 1'b1; pulse(3'b111);
        chk("R6 choice 3 never steps", pattern_o, 16'h0081);
        run_en = 1'b0; cyc();

        // short windows
        cur_req = "R9";
        load(1, 1'b0, 0, 16'hFFFF);
        run_en = 1'b1; pulse(3'b001); pulse(3'b001);
        chk("R9 length one holds", pattern_o, 16'h0001);
        run_en = 1'b0;
        load(0, 1'b1, 0, 16'hFFFF);
        run_en = 1'b1; pulse(3'b001);
        chk("R9 length zero holds", pattern_o, 16'h0000);
        run_en = 1'b0; cyc();

        // oversize length clamps to 16
        cur_req = "R2";
        load(25, 1'b1, 0, 16'h8001);
        chk("R2 oversize length", pattern_o, 16'h8001);
        run_en = 1'b1; pulse(3'b001);
        chk("R5 right wrap at 16", pattern_o, 16'hC000);
        run_en = 1'b0; cyc();

        // pseudo-random mixed traffic, judged by the model each clock
        cur_req = "R4/R5/R6/R7/R8";
        begin
            logic [31:0] lf = 32'h1234_5678;
            for (int n = 0; n < 600; n++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                run_en   = lf[3] | lf[9];
                cfg_we   = (lf[7:5] == 3'b000);
                cfg_len  = lf[14:10];
                cfg_dir  = lf[15];
                cfg_sel  = lf[17:16];
                cfg_init = lf[31:16];
                tick_in  = lf[20:18];
                cyc();
            end
        end
        cfg_we = 1'b0; tick_in = '0; run_en = 1'b0;
        cyc(2);
        finish_run();
    end

    initial begin
        #(8 * 50000);
        total++; bad++;
        $display("FAIL watchdog: act=running exp=finished");
        finish_run();
    end
endmodule